// File: doc/BRIEF.md
# PS/2 device-side byte transmitter

This block is the peripheral end of a PS/2 link and sends one byte towards the host. The device owns the clock on this link, so the block drives both the clock and the data wire. Each wire is open-drain: the block outputs a pull-low enable for it and reads back the level actually present on it. A byte is handed over with a one-cycle valid strobe while the block is idle. The block then holds `busy` high until the transfer either finishes, which it marks with a one-cycle `done`, or is cut short by the host, which it marks with a one-cycle `aborted`.

The block wraps the byte in an eleven-bit frame. It first waits for both wires to stay released for a quiet interval. It then paces every clock high phase, every clock low phase and the point where data is placed, using cycle counts derived from the system clock. While it has the clock released ahead of each falling edge, it watches the clock wire. If the host pulls the clock low there (inhibit), the block lets go of both wires and gives up. After the final clock it keeps `busy` for a guard interval, so that the host has room to inhibit before any following byte.

Top module: `ps2_dev_tx`

## Requirements
- R1: Each transfer produces exactly 11 clock low phases. The data wire level at the 11 falling edges is, in order: 0 (start), the 8 data bits with bit 0 first, an odd parity bit (so the nine data and parity bits hold an odd number of ones), and 1 (stop).
- R2: Every clock low phase lasts exactly LOW_CYC cycles.
- R3: Between two consecutive falling edges of a transfer, the clock stays released for exactly HIGH_CYC cycles.
- R4: The data drive changes only while the clock is released. When it changes ahead of a falling edge, it does so exactly SETUP_CYC cycles before that edge. It stays constant throughout each clock low phase.
- R5: After a byte is accepted, neither wire is driven until both wires have been sensed high for QUIET_CYC consecutive cycles. A low level on either wire restarts that count.
- R6: The block watches for the clock wire sensed low while it has the clock released before one of the 11 falling edges (every cycle of that phase except the first). If that happens, on the next cycle `aborted` pulses for one cycle, `busy` is low and both drive enables are low.
- R7: After the 11th clock returns high, `busy` stays high for exactly GAP_CYC more cycles. Then `done` pulses for one cycle, in the same cycle that `busy` drops. The host holding the clock low during this interval does not abort the transfer.
- R8: A valid strobe while `busy` is high is ignored: the frame in progress is unchanged and no second transfer follows.
- R9: While reset is high, and in the first cycle after it, `busy`, `done`, `aborted` and both drive enables are 0.
- R10: A valid strobe while idle is accepted, and `busy` is high from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | One-cycle strobe offering `tx_byte` |
| tx_byte | input | 8 | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: transfer completed |
| aborted | output | 1 | One-cycle pulse: host inhibit ended the transfer |
| clk_drive_low | output | 1 | Pull the clock wire low when 1 |
| dat_drive_low | output | 1 | Pull the data wire low when 1 |
| clk_line_in | input | 1 | Sensed level of the clock wire |
| dat_line_in | input | 1 | Sensed level of the data wire |

## Verification
The hardest case to reach is a host inhibit that lands inside a particular released-clock phase, before a chosen falling edge. It must hit after the one-cycle settle slot, and for the first edge it must also land before the start bit is committed. The bench follows the falling edges the device has already produced. For each of the eleven positions it waits for the clock release in front of the target edge, or for the start bit in the first case, and only then pulls the modelled clock wire low. An inhibit placed in the guard interval after the last clock checks the opposite case, where the same stimulus must be ignored.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUIET,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } tx_state_e;

    // Order inside the struct is wire order: start bit leaves first (LSB).
    typedef struct packed {
        logic              stop;
        logic              par;
        logic [BYTE_W-1:0] payload;
        logic              start;
    } frame_t;

    function automatic logic odd_parity(input logic [BYTE_W-1:0] d);
        return ~(^d);
    endfunction

    function automatic frame_t make_frame(input logic [BYTE_W-1:0] d);
        frame_t f;
        f.start   = 1'b0;
        f.payload = d;
        f.par     = odd_parity(d);
        f.stop    = 1'b1;
        return f;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/ps2tx_phase_timer.sv
module ps2tx_phase_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ps2tx_quiet_det.sv
module ps2tx_quiet_det #(
    parameter int QUIET_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clk_in,
    input  logic dat_in,
    output logic ok
);
    localparam int QW = $clog2(QUIET_CYC + 1);

    logic [QW-1:0] run;
    logic          both_high;

    assign both_high = clk_in & dat_in;

    always_ff @(posedge clk) begin
        if (rst || !en || !both_high)      run <= '0;
        else if (run != QW'(QUIET_CYC))    run <= run + 1'b1;
    end

    assign ok = en && both_high && (run >= QW'(QUIET_CYC - 1));
endmodule

// File: rtl/ps2tx_frame_shreg.sv
module ps2tx_frame_shreg
    import ps2tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              step,
    output logic              cur_bit
);
    logic [FRAME_BITS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)       sr <= '1;
        else if (load) sr <= make_frame(din);
        else if (step) sr <= {1'b1, sr[FRAME_BITS-1:1]};
    end

    assign cur_bit = sr[0];
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
    import ps2tx_pkg::*;
#(
    parameter int LOW_CYC   = 2000,
    parameter int HIGH_CYC  = 2000,
    parameter int SETUP_CYC = 750,
    parameter int QUIET_CYC = 2500,
    parameter int GAP_CYC   = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              busy,
    output logic              done,
    output logic              aborted,
    output logic              clk_drive_low,
    output logic              dat_drive_low,
    input  logic              clk_line_in,
    input  logic              dat_line_in
);
    localparam int MAXC   = max3(LOW_CYC, HIGH_CYC, GAP_CYC);
    localparam int CW     = $clog2(MAXC + 1);
    localparam int BIW    = $clog2(FRAME_BITS + 1);
    localparam int SET_AT = HIGH_CYC - SETUP_CYC - 1;

    tx_state_e      state, nstate;
    logic [CW-1:0]  cnt;
    logic [BIW-1:0] bit_idx;
    logic           phase_clr, load, step, abort_now, done_now;
    logic           quiet_ok, cur_bit, dat_q, done_q, abort_q;

    ps2tx_phase_timer #(.W(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (phase_clr),
        .cnt (cnt)
    );

    ps2tx_quiet_det #(.QUIET_CYC(QUIET_CYC)) u_quiet (
        .clk    (clk),
        .rst    (rst),
        .en     (state == ST_QUIET),
        .clk_in (clk_line_in),
        .dat_in (dat_line_in),
        .ok     (quiet_ok)
    );

    ps2tx_frame_shreg u_shreg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .din     (tx_byte),
        .step    (step),
        .cur_bit (cur_bit)
    );

    always_comb begin
        nstate    = state;
        phase_clr = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        abort_now = 1'b0;
        done_now  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                phase_clr = 1'b1;
                if (tx_valid) begin
                    load   = 1'b1;
                    nstate = ST_QUIET;
                end
            end
            ST_QUIET: begin
                phase_clr = 1'b1;
                if (quiet_ok) nstate = ST_HIGH;
            end
            ST_HIGH: begin
                if (cnt != '0 && !clk_line_in) begin
                    abort_now = 1'b1;
                    phase_clr = 1'b1;
                    nstate    = ST_IDLE;
                end else if (cnt == CW'(HIGH_CYC - 1)) begin
                    phase_clr = 1'b1;
                    nstate    = ST_LOW;
                end
            end
            ST_LOW: begin
                if (cnt == CW'(LOW_CYC - 1)) begin
                    phase_clr = 1'b1;
                    step      = 1'b1;
                    nstate    = (bit_idx == BIW'(FRAME_BITS - 1)) ? ST_GAP : ST_HIGH;
                end
            end
            ST_GAP: begin
                if (cnt == CW'(GAP_CYC - 1)) begin
                    phase_clr = 1'b1;
                    done_now  = 1'b1;
                    nstate    = ST_IDLE;
                end
            end
            default: begin
                phase_clr = 1'b1;
                nstate    = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            dat_q   <= 1'b0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state   <= nstate;
            done_q  <= done_now;
            abort_q <= abort_now;
            if (load)      bit_idx <= '0;
            else if (step) bit_idx <= bit_idx + 1'b1;
            if (nstate == ST_IDLE)
                dat_q <= 1'b0;
            else if (state == ST_HIGH && cnt == CW'(SET_AT))
                dat_q <= ~cur_bit;
        end
    end

    assign busy          = (state != ST_IDLE);
    assign done          = done_q;
    assign aborted       = abort_q;
    assign clk_drive_low = (state == ST_LOW);
    assign dat_drive_low = dat_q;

endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic busy,
    input logic done,
    input logic aborted,
    input logic clk_drive_low,
    input logic dat_drive_low
);
    p_idle_released_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!clk_drive_low && !dat_drive_low));

    p_abort_release_r6: assert property (@(posedge clk) disable iff (rst)
        aborted |-> (!busy && !clk_drive_low && !dat_drive_low));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_not_abort_r7: assert property (@(posedge clk) disable iff (rst)
        !(done && aborted));

    p_dat_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
        (clk_drive_low && $past(clk_drive_low)) |-> $stable(dat_drive_low));

    p_dat_at_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_drive_low) |-> $stable(dat_drive_low));

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && tx_valid) |=> busy);
endmodule

bind ps2_dev_tx ps2_dev_tx_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_valid      (tx_valid),
    .busy          (busy),
    .done          (done),
    .aborted       (aborted),
    .clk_drive_low (clk_drive_low),
    .dat_drive_low (dat_drive_low)
);

// File: tb/sim_ps2_dev_tx.sv
`timescale 1ns/1ps
module sim_ps2_dev_tx;
    localparam int LOWC  = 8;
    localparam int HIGHC = 8;
    localparam int SETC  = 3;
    localparam int QC    = 10;
    localparam int GAPC  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0;
    logic [7:0] tx_byte = '0;
    logic busy, done, aborted, clk_drive_low, dat_drive_low;
    logic host_clk_low = 1'b0;
    logic host_dat_low = 1'b0;
    logic clk_line, dat_line;

    assign clk_line = !(clk_drive_low || host_clk_low);
    assign dat_line = !(dat_drive_low || host_dat_low);

    always #10 clk = ~clk;

    ps2_dev_tx #(
        .LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .SETUP_CYC(SETC),
        .QUIET_CYC(QC), .GAP_CYC(GAPC)
    ) u0 (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .busy(busy), .done(done), .aborted(aborted),
        .clk_drive_low(clk_drive_low), .dat_drive_low(dat_drive_low),
        .clk_line_in(clk_line), .dat_line_in(dat_line)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wire monitor: reads the drive enables once per cycle away from the edge.
    logic        pck = 1'b0, pdl = 1'b0, pbusy = 1'b0;
    int          lowrun = 0, highrun = 0, sincechg = 0, nbits = 0;
    int          e_low = 0, e_hi = 0, e_set = 0, e_stab = 0;
    bit          chg = 1'b0;
    logic [10:0] bits = '0;

    always @(negedge clk) begin
        if (busy && !pbusy) begin
            nbits = 0; e_low = 0; e_hi = 0; e_set = 0; e_stab = 0;
            bits = '0; chg = 1'b0; lowrun = 0; highrun = 0; sincechg = 0;
        end
        if (clk_drive_low) begin
            if (!pck) begin
                if (nbits < 11) bits[nbits] = !dat_drive_low;
                if (nbits > 0 && highrun != HIGHC) e_hi++;
                if (chg && sincechg != SETC) e_set++;
                nbits++;
                lowrun = 1;
            end else begin
                lowrun++;
            end
            if (dat_drive_low != pdl) e_stab++;
        end else begin
            if (pck) begin
                if (lowrun != LOWC) e_low++;
                highrun = 1;
                chg = 1'b0;
            end else begin
                highrun++;
            end
            if (dat_drive_low != pdl) begin
                chg = 1'b1;
                sincechg = 1;
            end else if (chg) begin
                sincechg++;
            end
        end
        pck = clk_drive_low;
        pdl = dat_drive_low;
        pbusy = busy;
    end

    function automatic logic [10:0] exp_frame(input logic [7:0] b);
        return {1'b1, ~(^b), b, 1'b0};
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        chk(busy == 1'b0, "R10 idle before strobe", busy, 0);
        tx_valid = 1'b1;
        tx_byte  = b;
        @(negedge clk);
        tx_valid = 1'b0;
        #1;
        chk(busy == 1'b1, "R10 busy after strobe", busy, 1);
    endtask

    bit saw_abort;
    task automatic wait_idle();
        saw_abort = 1'b0;
        do begin
            @(negedge clk);
            #1;
            if (aborted) saw_abort = 1'b1;
        end while (busy);
    endtask

    task automatic check_frame(input logic [7:0] b);
        chk(nbits == 11, "R1 clock count", nbits, 11);
        chk(bits == exp_frame(b), "R1 frame bits", bits, exp_frame(b));
        chk(e_low == 0, "R2 low phase length errors", e_low, 0);
        chk(e_hi == 0, "R3 high phase length errors", e_hi, 0);
        chk(e_set == 0 && e_stab == 0, "R4 data timing errors", e_set + e_stab, 0);
        chk(done == 1'b1 && !saw_abort, "R7 done at end", done, 1);
        chk(highrun == GAPC + 1, "R7 guard length", highrun - 1, GAPC);
    endtask

    initial begin
        #(20 * 190000);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk({busy, done, aborted, clk_drive_low, dat_drive_low} == 5'b0,
            "R9 during reset", {busy, done, aborted, clk_drive_low, dat_drive_low}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, aborted, clk_drive_low, dat_drive_low} == 5'b0,
            "R9 after reset", {busy, done, aborted, clk_drive_low, dat_drive_low}, 0);

        // R1..R4, R7, R10: every byte value
        for (int b = 0; b < 256; b++) begin
            send(8'(b));
            wait_idle();
            check_frame(8'(b));
        end

        // R5: data held low by the host delays the start
        begin
            int drv;
            int n;
            host_dat_low = 1'b1;
            send(8'h5A);
            drv = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                #1;
                if (clk_drive_low || dat_drive_low) drv++;
            end
            chk(drv == 0, "R5 no drive while waiting", drv, 0);
            @(negedge clk);
            host_dat_low = 1'b0;
            n = 0;
            do begin
                @(negedge clk);
                #1;
                n++;
            end while (!dat_drive_low && n < 200);
            chk(n == QC + HIGHC - SETC, "R5 quiet wait then start bit", n, QC + HIGHC - SETC);
            wait_idle();
            check_frame(8'h5A);
        end

        // R8: strobe during a transfer is ignored
        begin
            int extra;
            send(8'h3C);
            repeat (50) @(negedge clk);
            tx_valid = 1'b1;
            tx_byte  = 8'hC3;
            @(negedge clk);
            tx_valid = 1'b0;
            wait_idle();
            chk(bits == exp_frame(8'h3C), "R8 frame unchanged", bits, exp_frame(8'h3C));
            extra = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                #1;
                if (busy || clk_drive_low || dat_drive_low) extra++;
            end
            chk(extra == 0, "R8 no second transfer", extra, 0);
        end

        // R6: inhibit before each of the 11 falling edges
        for (int k = 0; k < 11; k++) begin
            send(8'hA5);
            if (k == 0) begin
                do begin @(negedge clk); #1; end while (!dat_drive_low);
            end else begin
                do begin @(negedge clk); #1; end while (!(nbits == k && !clk_drive_low));
                @(negedge clk);
            end
            host_clk_low = 1'b1;
            @(negedge clk);
            #1;
            chk(aborted == 1'b1, "R6 aborted pulse", aborted, 1);
            chk({busy, clk_drive_low, dat_drive_low} == 3'b0, "R6 lines released",
                {busy, clk_drive_low, dat_drive_low}, 0);
            chk(nbits == k, "R6 no further falling edge", nbits, k);
            @(negedge clk);
            #1;
            chk(aborted == 1'b0, "R6 pulse width", aborted, 0);
            host_clk_low = 1'b0;
            repeat (3) @(negedge clk);
        end

        // R7: inhibit during the guard interval does not abort
        send(8'h81);
        do begin @(negedge clk); #1; end while (!(nbits == 11 && !clk_drive_low));
        host_clk_low = 1'b1;
        wait_idle();
        host_clk_low = 1'b0;
        chk(done == 1'b1 && !saw_abort, "R7 guard inhibit ignored", saw_abort, 0);
        chk(bits == exp_frame(8'h81), "R7 frame intact", bits, exp_frame(8'h81));

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule